// File: doc/BRIEF.md
# Microcontroller Clock Gating and Reset Sequencer

This block sits between the raw oscillator of a small 8-bit microcontroller and the rest of the core. It halves the oscillator rate to form the internal clock, counts machine cycles of twelve oscillator periods, and turns that into clock enables for the CPU and for the peripherals (timers, serial port, interrupt logic). It also decides when the oscillator itself may run.

Software requests a low-power state by strobing one of two request inputs. In light sleep the CPU enable stops and the peripherals keep their clock, so any active interrupt line can wake the core. In deep sleep the oscillator run enable drops, and only the external reset pin can bring the core back. The reset pin is synchronised and must stay high for two machine cycles of running clock before the synchronous internal reset asserts. That reset reinitialises registers and never clears memory. An external-access strap can be captured during internal reset when a lock option is set, so later changes on the pin have no effect.

Top module: `mcu_pwr_rst_ctrl`

## Requirements
- R1: The internal clock is the oscillator divided by two. While running, `cpu_clk_en` and `per_clk_en` are high on exactly every other oscillator cycle and never on two cycles in a row.
- R2: `mcyc_stb` pulses once every 12 oscillator cycles (6 divided ticks) while the oscillator runs.
- R3: `rst_pin` passes through a two-flop synchroniser. `sys_rst` asserts only after the synchronised pin has been high for 12 divided ticks (two machine cycles). A pin pulse of 22 oscillator cycles or less never asserts it, and a pulse of 26 or more always does. `sys_rst` falls within 4 oscillator cycles after the pin goes low.
- R4: In light sleep (`idle_flag`=1), `cpu_clk_en` stays 0 while `per_clk_en` keeps its half rate and `osc_run` stays 1.
- R5: Light sleep ends when any single bit of `irq_act` is high or when `sys_rst` asserts. `idle_flag` then clears by itself and the CPU enable resumes.
- R6: In deep sleep (`pdown_flag`=1 with the pin low), `osc_run`, `cpu_clk_en`, `per_clk_en` and `mcyc_stb` are all 0, and `irq_act` has no effect.
- R7: Deep sleep is left only through a qualified reset. A pin pulse too short to qualify raises `osc_run` while the pin is high, then drops it again, and the block stays in deep sleep. A qualified reset returns the block to run with `pdown_flag` cleared.
- R8: If both request strobes are high in the same cycle, deep sleep is entered and `idle_flag` stays 0.
- R9: With `lock_ea`=1, `ea_eff` holds the value `ea_pin` had during the last internal reset. With `lock_ea`=0, `ea_eff` follows `ea_pin` directly.
- R10: While `por_n` is low and on the first cycle after it rises, `sys_rst`=1, `osc_run`=1, and `idle_flag`=`pdown_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Raw oscillator clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| idle_set | input | 1 | One-cycle strobe requesting light sleep |
| pdown_set | input | 1 | One-cycle strobe requesting deep sleep |
| irq_act | input | NIRQ | Enabled interrupt requests, any bit high wakes light sleep |
| ea_pin | input | 1 | External-access strap level |
| lock_ea | input | 1 | Lock option: capture strap at reset |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run enable |
| mcyc_stb | output | 1 | Machine cycle strobe |
| sys_rst | output | 1 | Synchronous internal reset |
| idle_flag | output | 1 | Light sleep request pending |
| pdown_flag | output | 1 | Deep sleep request pending |
| ea_eff | output | 1 | Effective external-access level |

## Verification
On every cycle the assertions check several properties: the divided tick never fires twice in a row, the internal reset rises only from a high synchronised pin and falls once the pin drops, the CPU enable is off in light sleep, an interrupt wakes light sleep, and deep sleep holds while the pin is low. Some behaviour only the bench scenarios can show. These include the exact pulse-length boundary of reset qualification, and the counted half rate and twelve-cycle strobe period. They also include the short pin pulse that restarts the oscillator and then falls back into deep sleep, and the strap staying captured after the pin changes.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_PDOWN = 2'd2,
    PM_WAKE  = 2'd3
  } pm_state_t;
endpackage

// File: rtl/mpr_clkdiv.sv
module mpr_clkdiv #(
  parameter int TICKS_PER_MC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick,
  output logic mc_stb
);
  localparam int MW = (TICKS_PER_MC > 1) ? $clog2(TICKS_PER_MC) : 1;
  localparam logic [MW-1:0] MLAST = MW'(TICKS_PER_MC - 1);

  logic          ph_q, ph_d;
  logic [MW-1:0] mcnt_q, mcnt_d;

  always_comb begin
    ph_d   = ph_q;
    mcnt_d = mcnt_q;
    if (run) ph_d = ~ph_q;
    if (tick) mcnt_d = (mcnt_q == MLAST) ? '0 : mcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      mcnt_q <= '0;
    end else begin
      ph_q   <= ph_d;
      mcnt_q <= mcnt_d;
    end
  end

  assign tick   = run & ph_q;
  assign mc_stb = tick & (mcnt_q == MLAST);

  AST_DIV_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1
  AST_MCYC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mc_stb |=> !mc_stb); // R2
endmodule

// File: rtl/mpr_rst_qual.sv
module mpr_rst_qual #(
  parameter int TICKS_PER_MC = 6,
  parameter int RST_MCYC     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic tick,
  output logic pin_sync,
  output logic sys_rst
);
  localparam int QUAL = TICKS_PER_MC * RST_MCYC;
  localparam int QW   = $clog2(QUAL + 1);
  localparam logic [QW-1:0] QLIM = QW'(QUAL);

  logic          s1_q, s2_q;
  logic [QW-1:0] qcnt_q, qcnt_d;
  logic          rst_q, rst_d;

  always_comb begin
    qcnt_d = qcnt_q;
    if (!s2_q) qcnt_d = '0;
    else if (tick && qcnt_q != QLIM) qcnt_d = qcnt_q + 1'b1;
    rst_d = s2_q & (qcnt_q == QLIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      qcnt_q <= '0;
      rst_q  <= 1'b1;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      qcnt_q <= qcnt_d;
      rst_q  <= rst_d;
    end
  end

  assign pin_sync = s2_q;
  assign sys_rst  = rst_q;

  AST_RST_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(pin_sync)); // R3
  AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_sync |=> !sys_rst); // R3
endmodule

// File: rtl/mpr_mode_fsm.sv
module mpr_mode_fsm
  import mpr_pkg::*;
#(
  parameter int NIRQ = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle_set,
  input  logic            pdown_set,
  input  logic [NIRQ-1:0] irq,
  input  logic            pin_sync,
  input  logic            sys_rst,
  output pm_state_t       state
);
  pm_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PM_RUN: begin
        if (!sys_rst) begin
          if (pdown_set)     st_d = PM_PDOWN;
          else if (idle_set) st_d = PM_IDLE;
        end
      end
      PM_IDLE:  if (sys_rst || (|irq)) st_d = PM_RUN;
      PM_PDOWN: if (pin_sync) st_d = PM_WAKE;
      PM_WAKE: begin
        if (sys_rst)        st_d = PM_RUN;
        else if (!pin_sync) st_d = PM_PDOWN;
      end
      default: st_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PM_RUN;
    else        st_q <= st_d;
  end

  assign state = st_q;

  AST_IDLE_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_IDLE && (|irq)) |=> st_q == PM_RUN); // R5
  AST_PDOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_PDOWN && !pin_sync) |=> st_q == PM_PDOWN); // R7
  AST_BOTH_PDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_RUN && !sys_rst && pdown_set) |=> st_q == PM_PDOWN); // R8
endmodule

// File: rtl/mcu_pwr_rst_ctrl.sv
module mcu_pwr_rst_ctrl
  import mpr_pkg::*;
#(
  parameter int NIRQ         = 5,
  parameter int TICKS_PER_MC = 6,
  parameter int RST_MCYC     = 2
) (
  input  logic            osc_clk,
  input  logic            por_n,
  input  logic            rst_pin,
  input  logic            idle_set,
  input  logic            pdown_set,
  input  logic [NIRQ-1:0] irq_act,
  input  logic            ea_pin,
  input  logic            lock_ea,
  output logic            cpu_clk_en,
  output logic            per_clk_en,
  output logic            osc_run,
  output logic            mcyc_stb,
  output logic            sys_rst,
  output logic            idle_flag,
  output logic            pdown_flag,
  output logic            ea_eff
);
  pm_state_t state;
  logic      run, tick, mc_stb, pin_sync, rst_int;
  logic      ea_hold_q, ea_hold_d;

  assign run = (state != PM_PDOWN);

  mpr_clkdiv #(.TICKS_PER_MC(TICKS_PER_MC)) u_div (
    .clk(osc_clk), .rst_n(por_n), .run(run), .tick(tick), .mc_stb(mc_stb)
  );

  mpr_rst_qual #(.TICKS_PER_MC(TICKS_PER_MC), .RST_MCYC(RST_MCYC)) u_qual (
    .clk(osc_clk), .rst_n(por_n), .pin(rst_pin), .tick(tick),
    .pin_sync(pin_sync), .sys_rst(rst_int)
  );

  mpr_mode_fsm #(.NIRQ(NIRQ)) u_fsm (
    .clk(osc_clk), .rst_n(por_n), .idle_set(idle_set), .pdown_set(pdown_set),
    .irq(irq_act), .pin_sync(pin_sync), .sys_rst(rst_int), .state(state)
  );

  // Strap capture register: deliberately no power-on value.
  always_comb begin
    ea_hold_d = ea_hold_q;
    if (rst_int) ea_hold_d = ea_pin;
  end

  always_ff @(posedge osc_clk) begin
    ea_hold_q <= ea_hold_d;
  end

  assign cpu_clk_en = tick & (state == PM_RUN);
  assign per_clk_en = tick & ((state == PM_RUN) || (state == PM_IDLE));
  assign osc_run    = run;
  assign mcyc_stb   = mc_stb;
  assign sys_rst    = rst_int;
  assign idle_flag  = (state == PM_IDLE);
  assign pdown_flag = (state == PM_PDOWN) || (state == PM_WAKE);
  assign ea_eff     = lock_ea ? ea_hold_q : ea_pin;

  AST_IDLE_CPU_OFF: assert property (@(posedge osc_clk) disable iff (!por_n)
    idle_flag |-> !cpu_clk_en); // R4
  AST_PDOWN_OSC_OFF: assert property (@(posedge osc_clk) disable iff (!por_n)
    $rose(pdown_flag) |-> !osc_run); // R6
endmodule

// File: tb/mcu_pwr_rst_ctrl_test.sv
module mcu_pwr_rst_ctrl_test;
  localparam int NIRQ = 5;

  logic osc_clk = 1'b0;
  logic por_n, rst_pin, idle_set, pdown_set, ea_pin, lock_ea;
  logic [NIRQ-1:0] irq_act;
  logic cpu_clk_en, per_clk_en, osc_run, mcyc_stb, sys_rst;
  logic idle_flag, pdown_flag, ea_eff;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 osc_clk = ~osc_clk;

  mcu_pwr_rst_ctrl #(.NIRQ(NIRQ)) uut (
    .osc_clk(osc_clk), .por_n(por_n), .rst_pin(rst_pin), .idle_set(idle_set),
    .pdown_set(pdown_set), .irq_act(irq_act), .ea_pin(ea_pin), .lock_ea(lock_ea),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_run(osc_run),
    .mcyc_stb(mcyc_stb), .sys_rst(sys_rst), .idle_flag(idle_flag),
    .pdown_flag(pdown_flag), .ea_eff(ea_eff)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge osc_clk);
  endtask

  // Counts enables over n cycles, also flags back-to-back pulses
  task automatic count_en(input int n, output int ncpu, output int nper,
                          output int nstb, output bit dbl);
    logic prev = 1'b0;
    ncpu = 0; nper = 0; nstb = 0; dbl = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge osc_clk);
      ncpu += int'(cpu_clk_en);
      nper += int'(per_clk_en);
      nstb += int'(mcyc_stb);
      if (prev && per_clk_en) dbl = 1;
      prev = per_clk_en;
    end
  endtask

  task automatic pulse_pin(input int h, output bit seen, output bit tail_hi,
                           output bit osc_seen);
    seen = 0; osc_seen = 0;
    rst_pin = 1'b1;
    for (int i = 0; i < h; i++) begin
      @(negedge osc_clk);
      seen |= sys_rst;
      osc_seen |= osc_run;
    end
    rst_pin = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge osc_clk);
      seen |= sys_rst;
    end
    tail_hi = sys_rst;
    wait_n(2);
  endtask

  task automatic strobe(input bit i_s, input bit p_s);
    idle_set = i_s; pdown_set = p_s;
    @(negedge osc_clk);
    idle_set = 1'b0; pdown_set = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nc, np, ns;
    bit dbl, seen, tail, osc;
    por_n = 0; rst_pin = 0; idle_set = 0; pdown_set = 0;
    irq_act = '0; ea_pin = 0; lock_ea = 0;
    wait_n(3);
    chk(sys_rst == 1 && osc_run == 1 && !idle_flag && !pdown_flag, "R10 in reset",
        int'(sys_rst), 1);
    por_n = 1'b1;
    chk(sys_rst == 1, "R10 first cycle after por", int'(sys_rst), 1);
    wait_n(4);
    chk(sys_rst == 0, "R10 reset released", int'(sys_rst), 0);

    // R1 / R2 rates
    count_en(120, nc, np, ns, dbl);
    chk(nc == 60, "R1 cpu half rate", nc, 60);
    chk(np == 60 && !dbl, "R1 per half rate", np, 60);
    chk(ns == 10, "R2 machine cycle strobes", ns, 10);

    // R3 qualification sweep
    for (int h = 1; h <= 22; h++) begin
      pulse_pin(h, seen, tail, osc);
      chk(!seen, $sformatf("R3 short pulse %0d", h), int'(seen), 0);
    end
    for (int h = 26; h <= 40; h += 2) begin
      pulse_pin(h, seen, tail, osc);
      chk(seen, $sformatf("R3 long pulse %0d", h), int'(seen), 1);
      chk(!tail, $sformatf("R3 release after %0d", h), int'(tail), 0);
    end

    // R4 / R5 light sleep and irq wake per bit
    for (int b = 0; b < NIRQ; b++) begin
      strobe(1, 0);
      wait_n(1);
      chk(idle_flag == 1, "R4 idle entered", int'(idle_flag), 1);
      count_en(40, nc, np, ns, dbl);
      chk(nc == 0, "R4 cpu stopped", nc, 0);
      chk(np == 20 && osc_run, "R4 peripherals run", np, 20);
      irq_act = NIRQ'(1) << b;
      @(negedge osc_clk);
      irq_act = '0;
      wait_n(1);
      chk(idle_flag == 0, $sformatf("R5 irq bit %0d wakes", b), int'(idle_flag), 0);
      count_en(20, nc, np, ns, dbl);
      chk(nc == 10, "R5 cpu resumes", nc, 10);
    end
    strobe(1, 0);
    pulse_pin(30, seen, tail, osc);
    chk(seen && !idle_flag, "R5 reset wakes idle", int'(idle_flag), 0);

    // R6 / R7 deep sleep
    strobe(0, 1);
    wait_n(2);
    chk(pdown_flag && !osc_run, "R6 osc stopped", int'(osc_run), 0);
    irq_act = '1;
    count_en(20, nc, np, ns, dbl);
    irq_act = '0;
    chk(nc + np + ns == 0, "R6 all enables off", nc + np + ns, 0);
    chk(pdown_flag && !osc_run, "R6 irq ignored", int'(pdown_flag), 1);
    pulse_pin(10, seen, tail, osc);
    chk(osc && !seen, "R7 short pulse restarts osc", int'(osc), 1);
    chk(pdown_flag && !osc_run, "R7 back in deep sleep", int'(osc_run), 0);
    pulse_pin(40, seen, tail, osc);
    chk(seen, "R7 qualified reset", int'(seen), 1);
    chk(!pdown_flag && osc_run, "R7 run restored", int'(pdown_flag), 0);
    count_en(20, nc, np, ns, dbl);
    chk(nc == 10, "R7 cpu resumes", nc, 10);

    // R8 both requests
    strobe(1, 1);
    wait_n(1);
    chk(pdown_flag && !idle_flag, "R8 deep sleep wins", int'(pdown_flag), 1);
    pulse_pin(40, seen, tail, osc);

    // R9 strap capture
    lock_ea = 1; ea_pin = 1;
    pulse_pin(30, seen, tail, osc);
    ea_pin = 0;
    wait_n(2);
    chk(ea_eff == 1, "R9 captured high", int'(ea_eff), 1);
    lock_ea = 0;
    wait_n(1);
    chk(ea_eff == 0, "R9 unlocked follows low", int'(ea_eff), 0);
    ea_pin = 1;
    wait_n(1);
    chk(ea_eff == 1, "R9 unlocked follows high", int'(ea_eff), 1);
    lock_ea = 1; ea_pin = 0;
    pulse_pin(30, seen, tail, osc);
    ea_pin = 1;
    wait_n(2);
    chk(ea_eff == 0, "R9 captured low", int'(ea_eff), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule